// File: doc/BRIEF.md
# Condition Field Predicate Test Unit

This execution unit runs four related predicate instructions against a condition register. The register is held inside the unit as eight 4-bit fields. Each instruction compares selected bits of a source against a 4-bit mode pattern, and a 4-bit mask chooses which bits take part. The source is either a condition field or bit 0 of an integer operand. A bit counts as a hit when its mask bit is set and its mode bit equals the source bit. The four hit bits are then written back in one of three ways: as a whole condition field, as one selected condition bit, or as the low nibble of a 64-bit integer result.

The issue stage presents an instruction word whose primary opcode has already been matched, together with a valid strobe. The unit drives the integer register number combinationally, so the register file can return the operand in the same cycle. The register file also supplies a flag that is set when the register number is zero. A merge flag in the instruction selects how a field write treats bits outside the mask: with merge set they keep their old value, and with merge clear they become zero. In the single-bit form the same flag selects between an OR and an AND of the four hits.

Top module: `cond_pred_unit`

## Requirements
- R1: Instruction bits 19-20 (bit 0 is the word's most significant bit) select the variant: 00 field-to-integer, 01 integer-to-field, 10 single condition bit, 11 field-to-field. Any sequence of valid operations leaves the condition register and integer output as the per-variant rules below describe.
- R2: Mask is in bits 12-15, the merge flag M is bit 11, the source field is bits 16-18, and the mode is bits 27-30, with bit 26 zero. Hit bit i is mask[i] AND (mode[i] equals tested bit i). Bit 0 of each field, mask and mode is its most significant bit. Field 0 occupies bits 31:28 of `cr_view`.
- R3: Field-to-integer raises `int_we` in the cycle after the valid strobe. It places the hits in `int_result[3:0]`, with field bit 0 on bit 3, and sets every upper bit to zero. No other variant raises `int_we`.
- R4: Integer-to-field tests all four bits against bit 0 of `gpr_data`, or against 0 when `gpr_zero` is set. It writes the field named by bits 16-18.
- R5: In the integer-to-field and field-to-field variants with M=1, destination bits whose mask bit is 0 keep their old value.
- R6: In those same variants with M=0, the whole destination field is overwritten, and bits whose mask bit is 0 become 0.
- R7: Field-to-field reads the field named by bits 16-18 and writes the field named by bits 6-8.
- R8: The single-bit variant takes its destination from bits 6-10. Bits 8-10 name the field, and bits 6-7 name the bit in that field, where 0 is the field's most significant bit. That bit receives the OR of the hits when M=1 and the AND when M=0. All other condition bits are unchanged.
- R9: A cycle without `valid` changes no condition bit and leaves `int_we` low.
- R10: Reset clears all condition fields, `int_we` and `int_result`.
- R11: `gpr_addr` equals instruction bits 6-10 combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid | input | 1 | Instruction present this cycle |
| instr | input | 32 | Instruction word |
| gpr_data | input | 64 | Integer source operand |
| gpr_zero | input | 1 | Register number is zero: source reads as 0 |
| gpr_addr | output | 5 | Integer register number for read/write |
| int_result | output | 64 | Registered integer result |
| int_we | output | 1 | Integer result write enable |
| cr_view | output | 32 | Whole condition register, field 0 on top |

## Verification
Several properties are checked by assertions on every cycle. Masked-out destination bits must keep their old value under merge and must clear under overwrite. A single-bit write may flip at most one condition bit. Idle cycles must leave the register unchanged. The integer write enable may follow only a field-to-integer strobe, and its result may carry no hit outside the mask. A zero-register integer-to-field overwrite must equal the inverted mode under the mask.

Only the bench scenarios can show that the right field or bit is addressed and that the OR/AND choice follows M. They also confirm the exact hit pattern for each mode, the bit ordering inside the integer nibble, and the set/clear idioms built from a zero source. A randomised run compares every variant against an independent model of the register.

// File: rtl/cond_pred_pkg.sv
package cond_pred_pkg;
  localparam int FLD_W = 4;
  localparam int SEL_W = 3;
  localparam int REG_W = 5;

  typedef enum logic [1:0] {
    OP_FLD2INT = 2'b00,
    OP_INT2FLD = 2'b01,
    OP_BIT     = 2'b10,
    OP_FLD2FLD = 2'b11
  } cp_op_e;

  typedef struct packed {
    cp_op_e             op;
    logic               merge;
    logic [FLD_W-1:0]   mask;
    logic [FLD_W-1:0]   mode;
    logic [SEL_W-1:0]   src_fld;
    logic [REG_W-1:0]   rnum;
  } cp_dec_t;
endpackage

// File: rtl/cpt_decode.sv
module cpt_decode
  import cond_pred_pkg::*;
#(
  parameter int ILEN = 32
) (
  input  logic [ILEN-1:0] instr,
  output cp_dec_t         dec
);
  // Positions are numbered from the word's most significant bit.
  localparam int B_RNUM = ILEN - 1 - 6;
  localparam int B_M    = ILEN - 1 - 11;
  localparam int B_MASK = ILEN - 1 - 12;
  localparam int B_SRC  = ILEN - 1 - 16;
  localparam int B_OP   = ILEN - 1 - 19;
  localparam int B_MODE = ILEN - 1 - 27;

  always_comb begin
    dec.rnum    = instr[B_RNUM -: REG_W];
    dec.merge   = instr[B_M];
    dec.mask    = instr[B_MASK -: FLD_W];
    dec.src_fld = instr[B_SRC -: SEL_W];
    dec.op      = cp_op_e'(instr[B_OP -: 2]);
    dec.mode    = instr[B_MODE -: FLD_W];
  end
endmodule

// File: rtl/cpt_bit_test.sv
module cpt_bit_test #(
  parameter int W = 4
) (
  input  logic [W-1:0] mask,
  input  logic [W-1:0] mode,
  input  logic [W-1:0] tested,
  output logic [W-1:0] hits
);
  for (genvar i = 0; i < W; i++) begin : g_lane
    assign hits[i] = mask[i] & (mode[i] == tested[i]);
  end
endmodule

// File: rtl/cpt_crfile.sv
module cpt_crfile #(
  parameter int NFIELDS = 8,
  parameter int FW      = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [$clog2(NFIELDS)-1:0] waddr,
  input  logic [FW-1:0]              wdata,
  input  logic [$clog2(NFIELDS)-1:0] ra_a,
  output logic [FW-1:0]              rd_a,
  input  logic [$clog2(NFIELDS)-1:0] ra_b,
  output logic [FW-1:0]              rd_b,
  output logic [NFIELDS*FW-1:0]      dbg
);
  logic [FW-1:0] fld [NFIELDS];

  for (genvar f = 0; f < NFIELDS; f++) begin : g_fld
    always_ff @(posedge clk) begin
      if (rst)
        fld[f] <= '0;
      else if (we && waddr == f)
        fld[f] <= wdata;
    end
    assign dbg[(NFIELDS-1-f)*FW +: FW] = fld[f];
  end

  assign rd_a = fld[ra_a];
  assign rd_b = fld[ra_b];

  // R9: no write request, no change anywhere in the register
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(dbg));
endmodule

// File: rtl/cond_pred_unit.sv
module cond_pred_unit
  import cond_pred_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int ILEN    = 32,
  parameter int NFIELDS = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    valid,
  input  logic [ILEN-1:0]         instr,
  input  logic [XLEN-1:0]         gpr_data,
  input  logic                    gpr_zero,
  output logic [REG_W-1:0]        gpr_addr,
  output logic [XLEN-1:0]         int_result,
  output logic                    int_we,
  output logic [NFIELDS*FLD_W-1:0] cr_view
);
  localparam int CRW = NFIELDS * FLD_W;

  cp_dec_t          dec;
  logic [FLD_W-1:0] src_val, dst_old, tested, hits, fld_new, wval;
  logic [SEL_W-1:0] dst_idx;
  logic [1:0]       bsel;
  logic             red_bit, cr_we, src_lsb;

  cpt_decode #(.ILEN(ILEN)) u_dec (.instr(instr), .dec(dec));

  cpt_crfile #(.NFIELDS(NFIELDS), .FW(FLD_W)) u_cr (
    .clk(clk), .rst(rst), .we(cr_we), .waddr(dst_idx), .wdata(wval),
    .ra_a(dec.src_fld), .rd_a(src_val), .ra_b(dst_idx), .rd_b(dst_old),
    .dbg(cr_view)
  );

  assign gpr_addr = dec.rnum;
  assign src_lsb  = gpr_zero ? 1'b0 : gpr_data[0];
  assign tested   = (dec.op == OP_INT2FLD) ? {FLD_W{src_lsb}} : src_val;

  cpt_bit_test #(.W(FLD_W)) u_test (
    .mask(dec.mask), .mode(dec.mode), .tested(tested), .hits(hits)
  );

  always_comb begin
    case (dec.op)
      OP_INT2FLD: dst_idx = dec.src_fld;
      OP_BIT:     dst_idx = dec.rnum[SEL_W-1:0];
      default:    dst_idx = dec.rnum[REG_W-1 -: SEL_W];
    endcase
  end

  assign bsel    = dec.rnum[REG_W-1 -: 2];
  assign red_bit = dec.merge ? (|hits) : (&hits);
  assign fld_new = dec.merge ? (hits | (dst_old & ~dec.mask)) : hits;

  always_comb begin
    wval = fld_new;
    if (dec.op == OP_BIT) begin
      wval = dst_old;
      wval[~bsel] = red_bit;
    end
  end

  assign cr_we = valid && (dec.op != OP_FLD2INT);

  always_ff @(posedge clk) begin
    if (rst) begin
      int_we     <= 1'b0;
      int_result <= '0;
    end else begin
      int_we <= valid && (dec.op == OP_FLD2INT);
      if (valid && dec.op == OP_FLD2INT)
        int_result <= {{(XLEN-FLD_W){1'b0}}, hits};
    end
  end

  function automatic logic [FLD_W-1:0] fld_of(input logic [CRW-1:0] v,
                                              input logic [SEL_W-1:0] i);
    return v[(NFIELDS-1-int'(i))*FLD_W +: FLD_W];
  endfunction

  logic is_fld_op;
  assign is_fld_op = valid && (dec.op == OP_INT2FLD || dec.op == OP_FLD2FLD);

  // R5: merge keeps destination bits outside the mask
  p_merge_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (is_fld_op && dec.merge) |=>
      ((fld_of(cr_view, $past(dst_idx)) & ~$past(dec.mask)) ==
       ($past(dst_old) & ~$past(dec.mask))));

  // R6: overwrite clears destination bits outside the mask
  p_overwrite_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (is_fld_op && !dec.merge) |=>
      ((fld_of(cr_view, $past(dst_idx)) & ~$past(dec.mask)) == '0));

  // R4: zero-register overwrite yields inverted mode under the mask
  p_zero_src_r4: assert property (@(posedge clk) disable iff (rst)
    (valid && dec.op == OP_INT2FLD && gpr_zero && !dec.merge) |=>
      (fld_of(cr_view, $past(dst_idx)) == ($past(dec.mask) & ~$past(dec.mode))));

  // R8: single-bit form touches at most one condition bit
  p_single_bit_r8: assert property (@(posedge clk) disable iff (rst)
    (valid && dec.op == OP_BIT) |=> ($countones(cr_view ^ $past(cr_view)) <= 1));

  // R3: integer write only after a field-to-integer strobe
  p_int_we_src_r3: assert property (@(posedge clk) disable iff (rst)
    int_we |-> $past(valid && dec.op == OP_FLD2INT));

  // R3: no hit outside the mask reaches the integer result
  p_int_masked_r3: assert property (@(posedge clk) disable iff (rst)
    int_we |-> ((int_result[FLD_W-1:0] & ~$past(dec.mask)) == '0));
endmodule

// File: tb/cond_pred_unit_tb.sv
module cond_pred_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] gpr_data = '0;
  logic        gpr_zero = 1'b0;
  logic [4:0]  gpr_addr;
  logic [63:0] int_result;
  logic        int_we;
  logic [31:0] cr_view;

  int nvec = 0;
  int nfail = 0;

  logic [31:0] exp_cr = '0;
  logic [31:0] q_cr[$];
  logic        q_we[$];
  logic [63:0] q_res[$];
  string       q_tag[$];

  always #4 clk = ~clk;

  cond_pred_unit u_dut (
    .clk(clk), .rst(rst), .valid(valid), .instr(instr),
    .gpr_data(gpr_data), .gpr_zero(gpr_zero), .gpr_addr(gpr_addr),
    .int_result(int_result), .int_we(int_we), .cr_view(cr_view)
  );

  function automatic logic [31:0] mk(input logic [1:0] v, input logic [4:0] rn,
      input logic m, input logic [3:0] mask, input logic [2:0] sf,
      input logic [3:0] mode);
    logic [31:0] w = '0;
    w[31:26] = 6'd19;
    w[25:21] = rn;
    w[20]    = m;
    w[19:16] = mask;
    w[15:13] = sf;
    w[12:11] = v;
    w[4:1]   = mode;
    return w;
  endfunction

  function automatic logic [3:0] getf(input logic [31:0] c, input int f);
    return c[31-4*f -: 4];
  endfunction

  task automatic op(input logic [1:0] v, input logic [4:0] rn, input logic m,
      input logic [3:0] mask, input logic [2:0] sf, input logic [3:0] mode,
      input logic [63:0] opnd, input logic z, input string tag);
    logic [3:0] t, h, old, nv;
    logic       r, ewe;
    logic [63:0] eres;
    int df;
    @(negedge clk);
    instr = mk(v, rn, m, mask, sf, mode);
    gpr_data = opnd;
    gpr_zero = z;
    valid = 1'b1;
    t = (v == 2'b01) ? {4{z ? 1'b0 : opnd[0]}} : getf(exp_cr, int'(sf));
    h = '0;
    for (int i = 0; i < 4; i++) h[3-i] = mask[3-i] && (mode[3-i] == t[3-i]);
    ewe = 1'b0;
    eres = '0;
    case (v)
      2'b00: begin ewe = 1'b1; eres = {60'd0, h}; end
      2'b10: begin
        r = m ? (h != 0) : (h == 4'hF);
        exp_cr[31 - 4*int'(rn[2:0]) - int'(rn[4:3])] = r;
      end
      default: begin
        df = (v == 2'b01) ? int'(sf) : int'(rn[4:2]);
        old = getf(exp_cr, df);
        nv = m ? (h | (old & ~mask)) : h;
        exp_cr[31-4*df -: 4] = nv;
      end
    endcase
    q_cr.push_back(exp_cr);
    q_we.push_back(ewe);
    q_res.push_back(eres);
    q_tag.push_back(tag);
    #1;
    nvec++;
    if (gpr_addr !== rn) begin
      nfail++;
      $display("FAIL R11 gpr_addr actual %0h expected %0h", gpr_addr, rn);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      valid = 1'b0;
      instr = $urandom;
      gpr_data = {$urandom, $urandom};
      q_cr.push_back(exp_cr);
      q_we.push_back(1'b0);
      q_res.push_back('0);
      q_tag.push_back("R9");
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (q_cr.size() > 0) begin
      logic [31:0] ecr;
      logic        ewe;
      logic [63:0] eres;
      string       tg;
      ecr = q_cr.pop_front();
      ewe = q_we.pop_front();
      eres = q_res.pop_front();
      tg = q_tag.pop_front();
      nvec++;
      if (cr_view !== ecr || int_we !== ewe || (ewe && int_result !== eres)) begin
        nfail++;
        $display("FAIL %s cr/we/res actual %h/%b/%h expected %h/%b/%h",
                 tg, cr_view, int_we, int_result, ecr, ewe, eres);
      end
    end
  end

  initial begin
    #(8 * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    nvec++;
    if (cr_view !== '0 || int_we !== 1'b0 || int_result !== '0) begin
      nfail++;
      $display("FAIL R10 reset actual %h/%b/%h expected 0/0/0", cr_view, int_we, int_result);
    end
    rst = 1'b0;
    // R4: zero source, mode picks the pattern; field 2 <- 1010
    op(2'b01, 5'd0, 1'b0, 4'b1111, 3'd2, 4'b0101, 64'h1, 1'b1, "R4");
    // R4: operand bit 0 = 1 into field 5
    op(2'b01, 5'd7, 1'b0, 4'b1111, 3'd5, 4'b1100, 64'h3, 1'b0, "R4");
    // R4: zero flag overrides operand
    op(2'b01, 5'd0, 1'b0, 4'b1111, 3'd6, 4'b0011, 64'hFF, 1'b1, "R4");
    // R5: set idiom and clear idiom
    op(2'b01, 5'd0, 1'b1, 4'b0101, 3'd2, 4'b0000, 64'h0, 1'b1, "R5");
    op(2'b01, 5'd0, 1'b1, 4'b0011, 3'd2, 4'b1111, 64'h0, 1'b1, "R5");
    // R6: overwrite with partial mask
    op(2'b01, 5'd0, 1'b0, 4'b0011, 3'd5, 4'b0000, 64'h0, 1'b1, "R6");
    // R7, R2: field 2 -> field 4
    op(2'b11, 5'd16, 1'b0, 4'b1111, 3'd2, 4'b1100, 64'h0, 1'b0, "R7");
    // R5: field-to-field merge into field 5
    op(2'b11, 5'd20, 1'b1, 4'b1000, 3'd2, 4'b0000, 64'h0, 1'b0, "R5");
    // R3: field to integer
    op(2'b00, 5'd9, 1'b0, 4'b1010, 3'd2, 4'b1000, 64'h0, 1'b0, "R3");
    op(2'b00, 5'd9, 1'b0, 4'b0000, 3'd4, 4'b1111, 64'h0, 1'b0, "R3");
    // R8: OR into field 7 bit 2, then AND forms
    op(2'b10, 5'b10111, 1'b1, 4'b0001, 3'd2, 4'b0000, 64'h0, 1'b0, "R8");
    op(2'b10, 5'b00000, 1'b0, 4'b1111, 3'd2, 4'b1100, 64'h0, 1'b0, "R8");
    op(2'b10, 5'b10111, 1'b0, 4'b1111, 3'd2, 4'b1101, 64'h0, 1'b0, "R8");
    idle(4);
    // R1: mixed random operations
    for (int n = 0; n < 300; n++) begin
      logic z;
      z = ($urandom % 4) == 0;
      op(2'($urandom), 5'($urandom), 1'($urandom), 4'($urandom), 3'($urandom),
         4'($urandom), {$urandom, $urandom}, z, "R1");
      if (($urandom % 8) == 0) idle(1);
    end
    idle(2);
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule